// File: doc/BRIEF.md
# PCM serial audio port

This block is a synchronous serial port for one pair of PCM voice channels. An external master supplies the bit clock and the frame sync. Each frame carries two 16-bit channel words back to back, most significant bit first. On the serial data output the port shifts out two parallel transmit words. From the serial data input it builds two parallel receive words, and it flags each one with a single-cycle valid strobe and a channel indicator.

All serial inputs are sampled by a faster system clock through a two-stage synchronizer, and the port acts on the edges it detects there. The bit clock must run at no more than a quarter of the system clock rate. An 8-bit control register sets three things:

- which bit-clock edge launches output data and which edge captures input data;
- whether the sync rising edge leads the first data bit by half a bit clock or by a full bit clock;
- whether the serial output is forced low.

A mode field and a format field are stored and read back. Only their value 0 is implemented, so they do not change the serial behaviour.

Top module: `pcm_serial_port`

## Requirements
- R1: After reset the control register reads 0x00. A write stores the byte with bit 6 cleared. The fields are: bit 7 = output disable, bit 6 = reserved (always reads 0), bit 5 = sync lead, bit 4 = edge polarity, bits 3:2 = mode, bits 1:0 = format.
- R2: With edge polarity 0, output bits are launched after a rising edge of the bit clock and input bits are captured at a falling edge.
- R3: With edge polarity 1, the two edges swap: output is launched after a falling edge and input is captured at a rising edge.
- R4: With sync lead 0, the channel change (the launch of the first data bit) happens at the first launch edge after the sync rising edge. In this mode the sync rising edge coincides with a capture edge.
- R5: With sync lead 1, the channel change happens at the first launch edge that is at least the second bit-clock edge after the sync rising edge. If sync instead rises at a capture edge, the frame starts one bit period later than it would with sync lead 0.
- R6: While output disable is 1 the serial output is 0. Reception keeps working. Clearing the bit restores normal output on the next frame.
- R7: A frame sends the first-channel word and then the second-channel word, 16 bits each, MSB first. Both words are taken from the parallel inputs. The serial output is 0 before the channel change and after the 32nd bit period.
- R8: After the 16th and the 32nd captured bit, the received word appears with a one-cycle valid pulse. The channel indicator is 0 for the first word and 1 for the second.
- R9: A sync rising edge during a frame discards the partial receive word (no valid pulse) and restarts bit counting for a new frame.
- R10: Mode and format values other than 0 are stored and read back, and they leave serial transmit and receive unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_in | input | 1 | External bit clock |
| sync_in | input | 1 | External frame sync |
| sdin | input | 1 | Serial receive data |
| sdout | output | 1 | Serial transmit data |
| tx_word_a | input | 16 | First-channel transmit word, taken at its channel change |
| tx_word_b | input | 16 | Second-channel transmit word, taken at its channel change |
| rx_word | output | 16 | Last received channel word |
| rx_valid | output | 1 | One-cycle strobe for a new rx_word |
| rx_chan | output | 1 | Channel of rx_word: 0 first, 1 second |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |

## Verification
A wrong arming count or a wrong edge polarity shows up at once as a serial output word shifted by one bit period. The receive words then come back rotated, and the error is visible on the first frame after the fault. A bit counter that fails to restart on a mid-frame sync produces a valid pulse for a discarded partial word, or puts a valid pulse at the wrong place with the wrong channel indicator, within that same frame. The bench compares whole transmit and receive words for directed and random frames, so it catches these faults within one frame.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    // Control register layout; bit order is the software-visible map.
    typedef struct packed {
        logic       out_dis;    // bit 7: force serial output low
        logic       rsvd;       // bit 6: reads 0
        logic       sync_lead;  // bit 5: 0 half bit clock, 1 full bit clock
        logic       edge_pol;   // bit 4: 0 launch rise / capture fall
        logic [1:0] mode;       // bits 3:2: stored only
        logic [1:0] fmt;        // bits 1:0: stored only
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/pcm_sync_chain.sv
module pcm_sync_chain #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/pcm_ctrl_reg.sv
module pcm_ctrl_reg
    import pcm_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    output ctrl_t             cfg,
    output logic [CTRL_W-1:0] rdata
);

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr) begin
            ctrl_d = ctrl_t'(wdata);
        end
        ctrl_d.rsvd = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign cfg   = ctrl_q;
    assign rdata = ctrl_q;

    // R1: a write reads back with the reserved bit cleared
    a_r1_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> rdata == ($past(wdata) & 8'hBF));

endmodule

// File: rtl/pcm_frame_ctl.sv
module pcm_frame_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_lvl,
    input  logic sync_lvl,
    input  logic edge_pol,
    input  logic sync_lead,
    output logic launch,
    output logic capture,
    output logic frame_start,
    output logic frame_abort
);

    typedef struct packed {
        logic       bclk_prev;
        logic       sync_prev;
        logic       armed;
        logic [1:0] ecnt;
    } fstate_t;

    fstate_t st_d, st_q;
    logic    b_rise, b_fall, s_rise;
    logic [1:0] need;
    logic [1:0] cnt_n;

    always_comb begin
        b_rise      = bclk_lvl & ~st_q.bclk_prev;
        b_fall      = ~bclk_lvl & st_q.bclk_prev;
        s_rise      = sync_lvl & ~st_q.sync_prev;
        launch      = edge_pol ? b_fall : b_rise;
        capture     = edge_pol ? b_rise : b_fall;
        need        = sync_lead ? 2'd2 : 2'd1;
        cnt_n       = (st_q.ecnt == 2'd2) ? 2'd2 : st_q.ecnt + 2'd1;
        frame_start = 1'b0;
        frame_abort = 1'b0;

        st_d           = st_q;
        st_d.bclk_prev = bclk_lvl;
        st_d.sync_prev = sync_lvl;

        if (s_rise) begin
            // edge in the same cycle as the sync rise is not counted
            st_d.armed  = 1'b1;
            st_d.ecnt   = 2'd0;
            frame_abort = 1'b1;
        end else if (st_q.armed && (b_rise || b_fall)) begin
            st_d.ecnt = cnt_n;
            if (launch && (cnt_n >= need)) begin
                frame_start = 1'b1;
                st_d.armed  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4: a channel change only ever happens on a launch edge
    a_r4_start_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> launch);

    // R2/R3: launch and capture never coincide
    a_r2_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(launch && capture));

endmodule

// File: rtl/pcm_tx_shift.sv
module pcm_tx_shift #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              frame_abort,
    input  logic              launch,
    input  logic [WORD_W-1:0] word_a,
    input  logic [WORD_W-1:0] word_b,
    output logic              sd
);

    localparam int FRAME_BITS = 2 * WORD_W;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] HALF_BIT = CNT_W'(WORD_W - 1);

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] sh;
    } tstate_t;

    tstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_abort) begin
            st_d.active = 1'b0;
            st_d.sh     = '0;
        end else if (frame_start) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
            st_d.sh     = word_a;
        end else if (launch && st_q.active) begin
            if (st_q.cnt == LAST_BIT) begin
                st_d.active = 1'b0;
                st_d.sh     = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == HALF_BIT) begin
                    st_d.sh = word_b;
                end else begin
                    st_d.sh = {st_q.sh[WORD_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sd = st_q.active & st_q.sh[WORD_W-1];

    // R7: the first launched bit is the MSB of the first-channel word
    a_r7_start_loads_msb: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> sd == $past(word_a[WORD_W-1]));

    // R9: a restart silences the output until the new channel change
    a_r9_abort_quiets: assert property (@(posedge clk) disable iff (!rst_n)
        frame_abort |=> !sd);

endmodule

// File: rtl/pcm_rx_shift.sv
module pcm_rx_shift #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              frame_abort,
    input  logic              capture,
    input  logic              sd,
    output logic [WORD_W-1:0] word,
    output logic              valid,
    output logic              chan
);

    localparam int FRAME_BITS = 2 * WORD_W;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] HALF_BIT = CNT_W'(WORD_W - 1);

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] word;
        logic              valid;
        logic              chan;
    } rstate_t;

    rstate_t st_d, st_q;
    logic [WORD_W-1:0] sh_n;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        sh_n       = {st_q.sh[WORD_W-2:0], sd};
        if (frame_abort) begin
            st_d.active = 1'b0;
        end else if (frame_start) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end else if (capture && st_q.active) begin
            st_d.sh  = sh_n;
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == HALF_BIT || st_q.cnt == LAST_BIT) begin
                st_d.word  = sh_n;
                st_d.valid = 1'b1;
                st_d.chan  = (st_q.cnt == LAST_BIT);
            end
            if (st_q.cnt == LAST_BIT) begin
                st_d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word  = st_q.word;
    assign valid = st_q.valid;
    assign chan  = st_q.chan;

    // R8: a valid strobe lasts one cycle
    a_r8_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R8: a valid strobe follows a capture edge
    a_r8_valid_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(capture));

    // R9: a restart never produces a strobe for the partial word
    a_r9_abort_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        frame_abort |=> !valid);

endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
    import pcm_port_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_in,
    input  logic              sync_in,
    input  logic              sdin,
    output logic              sdout,
    input  logic [WORD_W-1:0] tx_word_a,
    input  logic [WORD_W-1:0] tx_word_b,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid,
    output logic              rx_chan,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata
);

    ctrl_t      cfg;
    logic [2:0] raw_in, syn_in;
    logic       launch, capture, frame_start, frame_abort;
    logic       tx_sd;

    assign raw_in = {bclk_in, sync_in, sdin};

    pcm_sync_chain #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in),
        .dout (syn_in)
    );

    pcm_ctrl_reg u_reg (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (reg_wr),
        .wdata(reg_wdata),
        .cfg  (cfg),
        .rdata(reg_rdata)
    );

    pcm_frame_ctl u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk_lvl   (syn_in[2]),
        .sync_lvl   (syn_in[1]),
        .edge_pol   (cfg.edge_pol),
        .sync_lead  (cfg.sync_lead),
        .launch     (launch),
        .capture    (capture),
        .frame_start(frame_start),
        .frame_abort(frame_abort)
    );

    pcm_tx_shift #(.WORD_W(WORD_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .frame_abort(frame_abort),
        .launch     (launch),
        .word_a     (tx_word_a),
        .word_b     (tx_word_b),
        .sd         (tx_sd)
    );

    pcm_rx_shift #(.WORD_W(WORD_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .frame_abort(frame_abort),
        .capture    (capture),
        .sd         (syn_in[0]),
        .word       (rx_word),
        .valid      (rx_valid),
        .chan       (rx_chan)
    );

    assign sdout = tx_sd & ~cfg.out_dis;

    // R6: writing the disable bit holds the serial output low
    a_r6_disable_low: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[7]) |=> !sdout);

endmodule

// File: tb/test_pcm_serial_port.sv
module test_pcm_serial_port;

    localparam int H = 4;  // system clocks per bit-clock half period

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_in = 1'b0, sync_in = 1'b0, sdin = 1'b0;
    logic        sdout;
    logic [15:0] tx_word_a = '0, tx_word_b = '0;
    logic [15:0] rx_word;
    logic        rx_valid, rx_chan;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;

    int nchk = 0, nfail = 0;
    bit finished = 0;

    int          rx_n = 0;
    logic [15:0] rx_log [256];
    logic        chan_log [256];

    always #2 clk = ~clk;

    pcm_serial_port i_pcm_serial_port (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .sync_in(sync_in),
        .sdin(sdin), .sdout(sdout), .tx_word_a(tx_word_a), .tx_word_b(tx_word_b),
        .rx_word(rx_word), .rx_valid(rx_valid), .rx_chan(rx_chan),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always @(posedge clk) begin
        if (rx_valid) begin
            rx_log[rx_n % 256]   <= rx_word;
            chan_log[rx_n % 256] <= rx_chan;
            rx_n <= rx_n + 1;
        end
    end

    function automatic logic [31:0] frame_bits(input logic [15:0] a, input logic [15:0] b);
        return {a, b};
    endfunction

    function automatic logic [7:0] ctrl_val(input logic dis, input logic lead,
                                            input logic pol, input logic [3:0] mf);
        return {dis, 1'b0, lead, pol, mf};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bedge(input logic lvl, input logic sy, input logic d);
        @(negedge clk);
        bclk_in = lvl;
        sync_in = sy;
        sdin = d;
        repeat (H - 1) @(negedge clk);
    endtask

    task automatic sync_seq(input logic lvl_l, input logic seq1);
        if (!seq1) begin
            bedge(lvl_l, 1'b0, 1'b0);
            bedge(~lvl_l, 1'b1, 1'b0);
        end else begin
            bedge(~lvl_l, 1'b0, 1'b0);
            bedge(lvl_l, 1'b1, 1'b0);
            bedge(~lvl_l, 1'b1, 1'b0);
        end
    endtask

    // One frame; skew = bit periods the channel change lags the first launch edge.
    task automatic do_frame(input string req, input logic pol, input logic seq1,
                            input int skew, input logic [15:0] ta, input logic [15:0] tb,
                            input logic [15:0] ra, input logic [15:0] rb,
                            input logic dis, input int cut);
        logic        lvl_l;
        logic [31:0] obs, rxbits;
        int          base;
        lvl_l = ~pol;
        rxbits = frame_bits(ra, rb);
        tx_word_a = ta;
        tx_word_b = tb;
        sync_seq(lvl_l, seq1);
        if (cut > 0) begin
            for (int k = 0; k < cut; k++) begin
                bedge(lvl_l, 1'b0, 1'($urandom_range(0, 1)));
                bedge(~lvl_l, 1'b0, sdin);
            end
            sync_seq(lvl_l, seq1);
        end
        base = rx_n;
        obs = '0;
        for (int k = 0; k < 32 + skew; k++) begin
            bedge(lvl_l, 1'b0, (k >= skew) ? rxbits[31 - (k - skew)] : 1'b0);
            if (k >= skew) obs[31 - (k - skew)] = sdout;
            else chk({req, " R5 idle before late start"}, {31'd0, sdout}, 32'd0);
            bedge(~lvl_l, 1'b0, sdin);
        end
        bedge(lvl_l, 1'b0, 1'b0);
        chk({req, " R7 output low after frame"}, {31'd0, sdout}, 32'd0);
        bedge(~lvl_l, 1'b0, 1'b0);
        chk({req, " R7/R6 tx frame"}, obs, dis ? 32'd0 : frame_bits(ta, tb));
        chk({req, " R8/R9 rx strobe count"}, rx_n - base, 32'd2);
        chk({req, " R8 rx first word"}, {16'd0, rx_log[base % 256]}, {16'd0, ra});
        chk({req, " R8 rx second word"}, {16'd0, rx_log[(base + 1) % 256]}, {16'd0, rb});
        chk({req, " R8 rx channel order"},
            {30'd0, chan_log[base % 256], chan_log[(base + 1) % 256]}, 32'd1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog R7 actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset value", {24'd0, reg_rdata}, 32'd0);
        chk("R7 reset output", {31'd0, sdout}, 32'd0);
        chk("R8 reset strobe", {31'd0, rx_valid}, 32'd0);

        wr_reg(8'hFF);
        chk("R1 reserved bit reads 0", {24'd0, reg_rdata}, 32'h000000BF);
        wr_reg(ctrl_val(1'b0, 1'b0, 1'b0, 4'hF));
        chk("R10 mode/format readback", {24'd0, reg_rdata}, 32'h0000000F);
        do_frame("R10 nonzero mode", 1'b0, 1'b0, 0, 16'h1357, 16'h9BDF, 16'h2468, 16'hACE0, 1'b0, 0);

        wr_reg(ctrl_val(1'b0, 1'b0, 1'b0, 4'h0));
        do_frame("R2 R4 pol0 lead0", 1'b0, 1'b0, 0, 16'hA5F0, 16'h1234, 16'hC3C3, 16'h8001, 1'b0, 0);

        wr_reg(ctrl_val(1'b0, 1'b0, 1'b1, 4'h0));
        do_frame("R3 pol1 lead0", 1'b1, 1'b0, 0, 16'h0F0F, 16'hF00D, 16'h7FFE, 16'h5555, 1'b0, 0);

        wr_reg(ctrl_val(1'b0, 1'b1, 1'b0, 4'h0));
        do_frame("R5 pol0 lead1", 1'b0, 1'b1, 0, 16'hDEAD, 16'hBEEF, 16'h0001, 16'hFFFF, 1'b0, 0);
        wr_reg(ctrl_val(1'b0, 1'b1, 1'b1, 4'h0));
        do_frame("R5 pol1 lead1", 1'b1, 1'b1, 0, 16'h8000, 16'h0001, 16'h1111, 16'hEEEE, 1'b0, 0);
        wr_reg(ctrl_val(1'b0, 1'b1, 1'b0, 4'h0));
        do_frame("R5 late sync lead1", 1'b0, 1'b0, 1, 16'hCAFE, 16'h0BAD, 16'h3C3C, 16'hA0A0, 1'b0, 0);

        wr_reg(ctrl_val(1'b1, 1'b0, 1'b0, 4'h0));
        chk("R1 disable readback", {24'd0, reg_rdata}, 32'h00000080);
        do_frame("R6 disabled", 1'b0, 1'b0, 0, 16'hFFFF, 16'hFFFF, 16'h6006, 16'h0990, 1'b1, 0);
        wr_reg(ctrl_val(1'b0, 1'b0, 1'b0, 4'h0));
        do_frame("R6 re-enabled", 1'b0, 1'b0, 0, 16'hFFFF, 16'h8421, 16'h1248, 16'h8124, 1'b0, 0);

        do_frame("R9 restart pol0", 1'b0, 1'b0, 0, 16'h7E57, 16'h0C0D, 16'h4321, 16'h8765, 1'b0, 10);
        wr_reg(ctrl_val(1'b0, 1'b1, 1'b1, 4'h0));
        do_frame("R9 restart pol1", 1'b1, 1'b1, 0, 16'h2222, 16'hDDDD, 16'h9999, 16'h6666, 1'b0, 20);

        for (int n = 0; n < 8; n++) begin
            logic p, s;
            p = 1'($urandom_range(0, 1));
            s = 1'($urandom_range(0, 1));
            wr_reg(ctrl_val(1'b0, s, p, 4'($urandom_range(0, 15))));
            do_frame("R2 R3 R7 random", p, s, 0, 16'($urandom), 16'($urandom),
                     16'($urandom), 16'($urandom), 1'b0, 0);
        end

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule